// File: doc/BRIEF.md
# Ethernet DMA Error Event Gate

This block sits between the error detectors of an Ethernet DMA controller and the logic that reacts to them. Each detector raises a one-cycle pulse on its own condition line. For every pulse the gate looks up one bit of a software-written suppression word. If that bit is clear, the gate applies the effects fixed for that error class. The possible effects are a sticky event bit, a strobe that tells the descriptor writer which status flag to set in the current buffer descriptor, and a halt of the transmit or receive descriptor queue.

If the suppression bit is set, every effect of that class is dropped together. The two receive-filing classes are different: when suppressed, they fire a discard strobe so the frame is thrown away without trace. Software clears event bits by writing ones. It releases a halted queue by pulsing that direction's restart line.

Top module: `dma_err_gate`

## Requirements
- R1: After reset, the suppression word, the event word, both halt outputs, the flag strobes and the discard strobe are all zero.
- R2: A suppression write stores bits 8..0 (0 busy, 1 system bus error, 2 babbling transmit, 3 transmit error, 4 late collision, 5 retry limit, 6 transmit underrun, 7 filer no result, 8 disabled ring target). The value reads back from the next cycle on. Bits 31..9 read as zero whatever is written.
- R3: Event bits use the same bit positions as R2. A bit is set on the clock edge that samples an enabled pulse. It stays set until a clear write has a one in that position. When a clear and a new enabled pulse hit the same bit in the same cycle, the bit ends up set. Clearing one bit leaves the other bits unchanged.
- R4: An enabled busy pulse sets event bit 0 and asserts the receive halt. It produces no flag strobe.
- R5: An enabled system bus error sets event bit 1 and asserts both the transmit halt and the receive halt.
- R6: An enabled babbling transmit pulse sets event bit 2 and strobes flag bit 0 for one cycle. It does not halt either queue.
- R7: An enabled transmit error sets event bit 3 only. It produces no strobe and no halt.
- R8: An enabled late collision, retry limit or underrun pulse sets its event bit (4, 5 or 6). It strobes flag bit 1, 2 or 3 respectively and asserts the transmit halt.
- R9: An enabled filer-no-result or disabled-ring pulse sets event bit 7 or 8 and does not discard. When the class is suppressed, the same pulse sets no event and strobes the discard output for one cycle.
- R10: A halt output stays high until its direction's restart pulse arrives alone. A restart in the same cycle as a new halting pulse leaves the halt high.
- R11: A suppressed class of busy, bus error or the transmit kinds produces no event, no flag strobe and no halt. Other classes keep working.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dis_wr_i | input | 1 | Write strobe for the suppression word |
| dis_wdata_i | input | 32 | Suppression word write data |
| evt_clr_i | input | 1 | Write-one-to-clear strobe for the event word |
| evt_clr_data_i | input | 32 | Mask of event bits to clear |
| cond_i | input | 9 | One-cycle condition pulses, one per class (R2 bit order) |
| tx_restart_i | input | 1 | Releases the transmit halt |
| rx_restart_i | input | 1 | Releases the receive halt |
| dis_o | output | 32 | Suppression word readback |
| evt_o | output | 32 | Event word |
| bd_flag_o | output | 4 | Descriptor flag strobes: 0 babble, 1 late collision, 2 retry limit, 3 underrun |
| tx_halt_o | output | 1 | Transmit descriptor queue halt request |
| rx_halt_o | output | 1 | Receive descriptor queue halt request |
| rx_discard_o | output | 1 | Silent frame discard strobe |

## Verification
Each class is pulsed by itself with the suppression word clear. This separates the classes' effect mixes, so a class that halts the wrong queue or raises the wrong flag strobe is caught. All classes are then pulsed together with everything suppressed, and a partly suppressed word is tried too; these show whether suppression removes the whole mix and whether the discard strobe goes only to the filing classes. Clear and new pulse on the same bit in one cycle, and restart and new halt in one cycle, check that the new condition wins. Idle cycles after a halt show that the halt is held.

// File: rtl/dma_err_gate_pkg.sv
package dma_err_gate_pkg;

  localparam int NUM_CLASS = 9;
  localparam int NUM_FLAG  = 4;

  localparam int CL_BUSY     = 0;
  localparam int CL_BUSERR   = 1;
  localparam int CL_BABBLE   = 2;
  localparam int CL_TXERR    = 3;
  localparam int CL_LATECOL  = 4;
  localparam int CL_RETRYLIM = 5;
  localparam int CL_UNDERRUN = 6;
  localparam int CL_FILERNR  = 7;
  localparam int CL_BADRING  = 8;

  typedef struct packed {
    logic ev;
    logic flag;
    logic halt_tx;
    logic halt_rx;
    logic drop;
  } effect_t;

  // Effect mix of one class for one pulse, given its suppression bit.
  function automatic effect_t class_effect(input int idx, input logic cond, input logic dis);
    effect_t e;
    e = '0;
    if (cond) begin
      if (!dis) begin
        e.ev = 1'b1;
        case (idx)
          CL_BUSY:     e.halt_rx = 1'b1;
          CL_BUSERR:   begin e.halt_tx = 1'b1; e.halt_rx = 1'b1; end
          CL_BABBLE:   e.flag = 1'b1;
          CL_LATECOL,
          CL_RETRYLIM,
          CL_UNDERRUN: begin e.flag = 1'b1; e.halt_tx = 1'b1; end
          default:     ;
        endcase
      end else if (idx == CL_FILERNR || idx == CL_BADRING) begin
        e.drop = 1'b1;
      end
    end
    return e;
  endfunction

  // Descriptor flag strobe slot used by a flag-raising class.
  function automatic logic [1:0] flag_slot(input int idx);
    case (idx)
      CL_LATECOL:  return 2'd1;
      CL_RETRYLIM: return 2'd2;
      CL_UNDERRUN: return 2'd3;
      default:     return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/err_class_policy.sv
module err_class_policy
  import dma_err_gate_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic cond_i,
  input  logic dis_i,
  output logic ev_o,
  output logic flag_o,
  output logic halt_tx_o,
  output logic halt_rx_o,
  output logic drop_o
);

  effect_t eff;

  always_comb eff = class_effect(IDX, cond_i, dis_i);

  assign ev_o      = eff.ev;
  assign flag_o    = eff.flag;
  assign halt_tx_o = eff.halt_tx;
  assign halt_rx_o = eff.halt_rx;
  assign drop_o    = eff.drop;

  // R11 / R9: a suppressed pulse never records an event
  always_comb begin
    if (dis_i) begin
      suppress_no_event_chk: assert (!ev_o && !flag_o && !halt_tx_o && !halt_rx_o);
    end
  end

endmodule

// File: rtl/err_event_reg.sv
module err_event_reg #(
  parameter int           W    = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] clr_mask;
  logic [W-1:0] set_eff;

  assign clr_mask = clr_we_i ? clr_data_i : '0;
  assign set_eff  = set_i & IMPL;

  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= ((q_o & ~clr_mask) | set_eff) & IMPL;
  end

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_o & $past(set_eff)) == $past(set_eff)));

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_o & $past(q_o & ~clr_mask)) == $past(q_o & ~clr_mask)));

  // R3
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_o & ~$past(q_o | set_eff)) == '0));

endmodule

// File: rtl/queue_halt_latch.sv
module queue_halt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic restart_i,
  output logic halt_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) halt_o <= 1'b0;
    else        halt_o <= req_i | (halt_o & ~restart_i);
  end

  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && !restart_i) |=> halt_o);

  // R10
  req_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> halt_o);

  // R10
  restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && !req_i) |=> !halt_o);

endmodule

// File: rtl/dma_err_gate.sv
module dma_err_gate
  import dma_err_gate_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dis_wr_i,
  input  logic [REG_W-1:0]     dis_wdata_i,
  input  logic                 evt_clr_i,
  input  logic [REG_W-1:0]     evt_clr_data_i,
  input  logic [NUM_CLASS-1:0] cond_i,
  input  logic                 tx_restart_i,
  input  logic                 rx_restart_i,
  output logic [REG_W-1:0]     dis_o,
  output logic [REG_W-1:0]     evt_o,
  output logic [NUM_FLAG-1:0]  bd_flag_o,
  output logic                 tx_halt_o,
  output logic                 rx_halt_o,
  output logic                 rx_discard_o
);

  localparam logic [REG_W-1:0] IMPL_MASK = {{(REG_W-NUM_CLASS){1'b0}}, {NUM_CLASS{1'b1}}};
  localparam int               NUM_DIR   = 2;
  localparam int               DIR_TX    = 0;
  localparam int               DIR_RX    = 1;

  logic [REG_W-1:0]     dis_q;
  logic [NUM_CLASS-1:0] cls_ev, cls_flag, cls_htx, cls_hrx, cls_drop;
  logic [REG_W-1:0]     evt_set;
  logic [NUM_FLAG-1:0]  flag_set;
  logic                 drop_any;
  logic [NUM_DIR-1:0]   halt_req, halt_restart, halt_q;
  logic [NUM_FLAG-1:0]  flag_q;
  logic                 discard_q;

  // Suppression word
  always_ff @(posedge clk) begin
    if (!rst_n)        dis_q <= '0;
    else if (dis_wr_i) dis_q <= dis_wdata_i & IMPL_MASK;
  end

  // Per-class gating
  for (genvar k = 0; k < NUM_CLASS; k++) begin : g_cls
    err_class_policy #(.IDX(k)) u_pol (
      .cond_i    (cond_i[k]),
      .dis_i     (dis_q[k]),
      .ev_o      (cls_ev[k]),
      .flag_o    (cls_flag[k]),
      .halt_tx_o (cls_htx[k]),
      .halt_rx_o (cls_hrx[k]),
      .drop_o    (cls_drop[k])
    );
  end

  assign evt_set  = {{(REG_W-NUM_CLASS){1'b0}}, cls_ev};
  assign drop_any = |cls_drop;

  always_comb begin
    flag_set = '0;
    for (int k = 0; k < NUM_CLASS; k++) begin
      if (cls_flag[k]) flag_set[flag_slot(k)] = 1'b1;
    end
  end

  err_event_reg #(.W(REG_W), .IMPL(IMPL_MASK)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (evt_set),
    .clr_we_i   (evt_clr_i),
    .clr_data_i (evt_clr_data_i),
    .q_o        (evt_o)
  );

  // Halt latches, one per direction
  assign halt_req[DIR_TX]     = |cls_htx;
  assign halt_req[DIR_RX]     = |cls_hrx;
  assign halt_restart[DIR_TX] = tx_restart_i;
  assign halt_restart[DIR_RX] = rx_restart_i;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    queue_halt_latch u_halt (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (halt_req[d]),
      .restart_i (halt_restart[d]),
      .halt_o    (halt_q[d])
    );
  end

  // Registered one-cycle strobes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q    <= '0;
      discard_q <= 1'b0;
    end else begin
      flag_q    <= flag_set;
      discard_q <= drop_any;
    end
  end

  assign dis_o        = dis_q;
  assign bd_flag_o    = flag_q;
  assign tx_halt_o    = halt_q[DIR_TX];
  assign rx_halt_o    = halt_q[DIR_RX];
  assign rx_discard_o = discard_q;

  // R9
  discard_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_discard_o |-> $past(drop_any));

  // R9
  discard_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_any |-> ((cls_drop & cls_ev) == '0));

  // R8
  tx_halt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_halt_o) |-> $past(halt_req[DIR_TX]));

  // R4
  rx_halt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_halt_o) |-> $past(halt_req[DIR_RX]));

  // R6
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bd_flag_o != '0) |-> $past(cls_flag != '0));

  // R11
  for (genvar k = 0; k < NUM_CLASS; k++) begin : g_supp_chk
    // R11
    no_evt_when_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_i[k] && dis_q[k] && !evt_o[k]) |=> !evt_o[k]);
  end

endmodule

// File: tb/dma_err_gate_bench.sv
`timescale 1ns/1ps
module dma_err_gate_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dis_wr;
  logic [31:0] dis_wdata;
  logic        evt_clr;
  logic [31:0] evt_clr_data;
  logic [8:0]  cond;
  logic        tx_restart, rx_restart;
  logic [31:0] dis_o, evt_o;
  logic [3:0]  bd_flag;
  logic        tx_halt, rx_halt, rx_discard;

  always #2 clk = ~clk;

  dma_err_gate u_dma_err_gate (
    .clk            (clk),
    .rst_n          (rst_n),
    .dis_wr_i       (dis_wr),
    .dis_wdata_i    (dis_wdata),
    .evt_clr_i      (evt_clr),
    .evt_clr_data_i (evt_clr_data),
    .cond_i         (cond),
    .tx_restart_i   (tx_restart),
    .rx_restart_i   (rx_restart),
    .dis_o          (dis_o),
    .evt_o          (evt_o),
    .bd_flag_o      (bd_flag),
    .tx_halt_o      (tx_halt),
    .rx_halt_o      (rx_halt),
    .rx_discard_o   (rx_discard)
  );

  typedef struct {
    string       tag;
    logic [31:0] dis;
    logic [31:0] evt;
    logic [3:0]  flg;
    logic        txh;
    logic        rxh;
    logic        drp;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  logic [31:0] m_dis, m_evt;
  logic        m_txh, m_rxh;

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(string tag, logic [8:0] c, logic dw = 1'b0, logic [31:0] dd = '0,
                      logic cw = 1'b0, logic [31:0] cd = '0,
                      logic txr = 1'b0, logic rxr = 1'b0);
    exp_t        e;
    logic [31:0] set;
    logic [3:0]  fl;
    logic        th, rh, dr;
    @(negedge clk);
    cond = c; dis_wr = dw; dis_wdata = dd; evt_clr = cw; evt_clr_data = cd;
    tx_restart = txr; rx_restart = rxr;
    set = '0; fl = '0; th = 1'b0; rh = 1'b0; dr = 1'b0;
    for (int k = 0; k < 9; k++) begin
      if (c[k]) begin
        if (m_dis[k]) begin
          if (k >= 7) dr = 1'b1;
        end else begin
          set[k] = 1'b1;
          if (k == 0) rh = 1'b1;
          if (k == 1) begin th = 1'b1; rh = 1'b1; end
          if (k == 2) fl[0] = 1'b1;
          if (k >= 4 && k <= 6) begin fl[k-3] = 1'b1; th = 1'b1; end
        end
      end
    end
    m_evt = (m_evt & ~(cw ? cd : 32'h0)) | set;
    m_txh = th | (m_txh & ~txr);
    m_rxh = rh | (m_rxh & ~rxr);
    if (dw) m_dis = dd & 32'h0000_01FF;
    e.tag = tag; e.dis = m_dis; e.evt = m_evt; e.flg = fl;
    e.txh = m_txh; e.rxh = m_rxh; e.drp = dr;
    sb.push_back(e);
  endtask

  task automatic cleanup();
    step("R3", 9'h000, 1'b0, '0, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1);
  endtask

  // Monitor: compares the design after each edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        cmp(e.tag, "dis",     dis_o,              e.dis);
        cmp(e.tag, "evt",     evt_o,              e.evt);
        cmp(e.tag, "flag",    {28'h0, bd_flag},   {28'h0, e.flg});
        cmp(e.tag, "txhalt",  {31'h0, tx_halt},   {31'h0, e.txh});
        cmp(e.tag, "rxhalt",  {31'h0, rx_halt},   {31'h0, e.rxh});
        cmp(e.tag, "discard", {31'h0, rx_discard},{31'h0, e.drp});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cond = '0; dis_wr = 1'b0; dis_wdata = '0; evt_clr = 1'b0;
    evt_clr_data = '0; tx_restart = 1'b0; rx_restart = 1'b0;
    m_dis = '0; m_evt = '0; m_txh = 1'b0; m_rxh = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(posedge clk); #1;
    cmp("R1", "dis",  dis_o, 32'h0);
    cmp("R1", "evt",  evt_o, 32'h0);
    cmp("R1", "outs", {26'h0, bd_flag, tx_halt, rx_halt}, 32'h0);
    cmp("R1", "discard", {31'h0, rx_discard}, 32'h0);

    // R2 reserved bits ignore writes
    step("R2", 9'h000, 1'b1, 32'hFFFF_FFFF);
    step("R2", 9'h000);
    // R11 / R9 everything suppressed
    step("R11", 9'h1FF);
    step("R11", 9'h000);
    step("R2", 9'h000, 1'b1, 32'h0);

    // Each class alone, enabled
    step("R4", 9'h001); step("R4", 9'h000); cleanup();
    step("R5", 9'h002); step("R5", 9'h000); cleanup();
    step("R6", 9'h004); step("R6", 9'h000); cleanup();
    step("R7", 9'h008); step("R7", 9'h000); cleanup();
    step("R8", 9'h010); step("R8", 9'h000); cleanup();
    step("R8", 9'h020); step("R8", 9'h000); cleanup();
    step("R8", 9'h040); step("R8", 9'h000); cleanup();
    step("R9", 9'h080); step("R9", 9'h100); step("R9", 9'h000); cleanup();

    // R3 clear and set collide; partial clear
    step("R3", 9'h008);
    step("R3", 9'h008, 1'b0, '0, 1'b1, 32'h0000_0008);
    step("R3", 9'h004);
    step("R3", 9'h000, 1'b0, '0, 1'b1, 32'h0000_0004);
    step("R3", 9'h000);
    cleanup();

    // R10 halt held, restart versus new halt
    step("R10", 9'h010);
    step("R10", 9'h000); step("R10", 9'h000); step("R10", 9'h000);
    step("R10", 9'h020, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
    step("R10", 9'h000, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
    step("R10", 9'h001);
    step("R10", 9'h000, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
    step("R10", 9'h000, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1);
    cleanup();

    // R11 partial suppression
    step("R11", 9'h000, 1'b1, 32'h0000_0072);
    step("R11", 9'h072);
    step("R11", 9'h001);
    step("R11", 9'h000);
    cleanup();

    // R9 filer class partly suppressed
    step("R9", 9'h000, 1'b1, 32'h0000_0080);
    step("R9", 9'h180);
    step("R9", 9'h080);
    step("R9", 9'h000);
    cleanup();

    // Mixed simultaneous pulses, nothing suppressed
    step("R2", 9'h000, 1'b1, 32'h0);
    step("R8", 9'h07C);
    step("R8", 9'h000);
    cleanup();

    wait (sb.size() == 0);
    @(posedge clk); #1;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule